// File: doc/BRIEF.md
# Grouped-Priority Vectored Interrupt Controller

This block collects a vector of single-bit interrupt requests and a 4-bit encoded external level. It picks the most urgent request that is allowed through and hands the CPU a 12-bit event code together with the winning priority. The internal sources are arranged in groups of `SRC_PER_GRP` consecutive indices. Each group shares one 4-bit priority field. Four such fields are packed into each 16-bit priority register.

A 32-bit mask register blocks individual sources. Software changes it through two write addresses: one ORs ones into the mask and the other clears the bits written as ones. The external level input does not use a priority register. It carries its own priority, derived from the level code, and it has its own fixed code range.

The CPU supplies its current interrupt level. A request is raised only when the winner's priority is above that level. The code, priority and request outputs are all registered.

Top module: `grp_prio_intc`

## Requirements
- R1: Priority register k sits at write/read address k (k below the number of registers). Its bits [4j+3:4j] hold the priority of group 4k+j. Source i belongs to group i / SRC_PER_GRP. Bits 31:16 of a write to a priority register are dropped, and those bits read back as zero.
- R2: Internal source i, when it wins, produces event code CODE_BASE + 0x20*i (0x400 + 0x20*i by default), and irq_prio shows its group's priority.
- R3: An external level L from 0 to 14 is a request with code 0x200 + 0x20*L and priority 15 - L. L = 15 is no request. With no other candidate and L = 15, irq_prio and irq_code are 0.
- R4: A write to address 4 sets every mask bit whose data bit is 1. A write to address 5 clears every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged. Mask bit i = 1 blocks source i. The mask reads back at address 4 and at address 5.
- R5: A source whose group priority field is 0 never wins, and it never raises a request.
- R6: Among pending unmasked candidates, the highest priority wins. Ties go to the lowest source index. The external level request wins only when its priority is strictly above every internal candidate.
- R7: irq_req is 1 only when the winning priority is strictly greater than cpu_lvl. irq_code and irq_prio show the winner even when irq_req is 0.
- R8: The outputs reflect the inputs and register contents sampled at the previous rising clock edge. They do not change between edges.
- R9: During and after synchronous reset, all priority fields are 0, all 32 mask bits are 1, and irq_req, irq_prio and irq_code are 0.
- R10: rd_data returns the register at rd_addr one cycle later. Addresses that hold no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Registered read data |
| src_req | input | N_SRC | Internal request lines, active high |
| ext_lvl | input | 4 | Encoded external level, 15 = idle |
| cpu_lvl | input | 4 | Current CPU interrupt level |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_code | output | 12 | Event code of the winner |
| irq_prio | output | 4 | Priority of the winner |

## Verification
The assertions assume that src_req, ext_lvl, cpu_lvl and the write port change only once per clock period, so the sampled values are the ones the registered outputs react to. They also assume that no write is issued while reset is held. The stimulus changes every input on the falling edge and waits for reset release before any register access. Each scenario keeps its inputs steady across the capturing edge before the outputs are compared with the arithmetic model.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
  localparam int PRIO_W     = 4;
  localparam int CODE_W     = 12;
  localparam int REG_W      = 32;
  localparam int PREG_W     = 16;
  localparam int FLD_PER_RG = PREG_W / PRIO_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam prio_t EXT_IDLE  = 4'hF;
  localparam code_t EXT_BASE  = 12'h200;
  localparam code_t CODE_STEP = 12'h020;

  // code for an encoded external level: base plus one step per level
  function automatic code_t ext_code(input prio_t lvl);
    return EXT_BASE + code_t'(lvl) * CODE_STEP;
  endfunction

  // lower encoded levels are more urgent
  function automatic prio_t ext_prio(input prio_t lvl);
    return EXT_IDLE - lvl;
  endfunction
endpackage

// File: rtl/gpi_regs.sv
module gpi_regs
  import gpi_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int N_GRP     = 4,
  parameter int N_PREG    = 1,
  parameter int ADDR_W    = 3,
  parameter int MSET_ADDR = 4,
  parameter int MCLR_ADDR = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  output logic [N_GRP*PRIO_W-1:0] grp_prio,
  output logic [N_SRC-1:0]        src_mask
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(MSET_ADDR);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(MCLR_ADDR);

  logic [PREG_W-1:0] prio_q [N_PREG];
  logic [REG_W-1:0]  mask_q;
  logic [REG_W-1:0]  rd_next;

  // priority registers, one write decode per register
  for (genvar k = 0; k < N_PREG; k++) begin : g_preg
    always_ff @(posedge clk) begin
      if (rst)
        prio_q[k] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(k))
        prio_q[k] <= wr_data[PREG_W-1:0];
    end
  end

  // fan the packed fields out per group
  for (genvar g = 0; g < N_GRP; g++) begin : g_fld
    assign grp_prio[g*PRIO_W +: PRIO_W] =
      prio_q[g / FLD_PER_RG][(g % FLD_PER_RG)*PRIO_W +: PRIO_W];
  end

  // mask: separate set and clear addresses
  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '1;
    else if (wr_en && wr_addr == SET_A)
      mask_q <= mask_q | wr_data;
    else if (wr_en && wr_addr == CLR_A)
      mask_q <= mask_q & ~wr_data;
  end

  assign src_mask = mask_q[N_SRC-1:0];

  always_comb begin
    rd_next = '0;
    if (rd_addr == SET_A || rd_addr == CLR_A)
      rd_next = mask_q;
    for (int k = 0; k < N_PREG; k++)
      if (rd_addr == ADDR_W'(k))
        rd_next = {{(REG_W-PREG_W){1'b0}}, prio_q[k]};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SET_A) |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CLR_A) |=> ((mask_q & $past(wr_data)) == '0)); // R4
  AST_RST_STATE: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '1 && prio_q[0] == '0 && rd_data == '0)); // R9
endmodule

// File: rtl/gpi_arbiter.sv
module gpi_arbiter
  import gpi_pkg::*;
#(
  parameter int    N_SRC       = 8,
  parameter int    SRC_PER_GRP = 2,
  parameter int    N_GRP       = 4,
  parameter code_t CODE_BASE   = 12'h400
) (
  input  logic [N_SRC-1:0]        src_req,
  input  logic [N_SRC-1:0]        src_mask,
  input  logic [N_GRP*PRIO_W-1:0] grp_prio,
  input  prio_t                   ext_lvl,
  output logic                    win_vld,
  output prio_t                   win_prio,
  output code_t                   win_code
);
  prio_t cand [N_SRC];

  // per-source effective priority, zero when not eligible
  for (genvar i = 0; i < N_SRC; i++) begin : g_cand
    localparam int GI = i / SRC_PER_GRP;
    assign cand[i] = (src_req[i] && !src_mask[i]) ? grp_prio[GI*PRIO_W +: PRIO_W] : '0;
  end

  always_comb begin
    win_vld  = 1'b0;
    win_prio = '0;
    win_code = '0;
    // strict compare keeps the lowest index on ties and skips priority 0
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] > win_prio) begin
        win_vld  = 1'b1;
        win_prio = cand[i];
        win_code = CODE_BASE + code_t'(i) * CODE_STEP;
      end
    end
    if (ext_lvl != EXT_IDLE && ext_prio(ext_lvl) > win_prio) begin
      win_vld  = 1'b1;
      win_prio = ext_prio(ext_lvl);
      win_code = ext_code(ext_lvl);
    end
  end
endmodule

// File: rtl/gpi_outreg.sv
module gpi_outreg
  import gpi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  win_vld,
  input  prio_t win_prio,
  input  code_t win_code,
  input  prio_t cpu_lvl,
  output logic  irq_req,
  output prio_t irq_prio,
  output code_t irq_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_prio <= '0;
      irq_code <= '0;
    end else begin
      irq_req  <= win_vld && (win_prio > cpu_lvl);
      irq_prio <= win_prio;
      irq_code <= win_code;
    end
  end

  AST_REQ_ABOVE_LVL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_prio > $past(cpu_lvl))); // R7
  AST_CODE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (irq_prio != '0) |-> (irq_code[4:0] == 5'd0 && irq_code >= EXT_BASE)); // R2
endmodule

// File: rtl/grp_prio_intc.sv
module grp_prio_intc
  import gpi_pkg::*;
#(
  parameter int    N_SRC       = 8,
  parameter int    SRC_PER_GRP = 2,
  parameter int    ADDR_W      = 3,
  parameter int    MSET_ADDR   = 4,
  parameter int    MCLR_ADDR   = 5,
  parameter code_t CODE_BASE   = 12'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [N_SRC-1:0]  src_req,
  input  logic [3:0]        ext_lvl,
  input  logic [3:0]        cpu_lvl,
  output logic              irq_req,
  output logic [11:0]       irq_code,
  output logic [3:0]        irq_prio
);
  localparam int N_GRP  = (N_SRC + SRC_PER_GRP - 1) / SRC_PER_GRP;
  localparam int N_PREG = (N_GRP + FLD_PER_RG - 1) / FLD_PER_RG;

  logic [N_GRP*PRIO_W-1:0] grp_prio;
  logic [N_SRC-1:0]        src_mask;
  logic                    win_vld;
  prio_t                   win_prio;
  code_t                   win_code;

  gpi_regs #(
    .N_SRC(N_SRC), .N_GRP(N_GRP), .N_PREG(N_PREG), .ADDR_W(ADDR_W),
    .MSET_ADDR(MSET_ADDR), .MCLR_ADDR(MCLR_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .grp_prio(grp_prio), .src_mask(src_mask)
  );

  gpi_arbiter #(
    .N_SRC(N_SRC), .SRC_PER_GRP(SRC_PER_GRP), .N_GRP(N_GRP), .CODE_BASE(CODE_BASE)
  ) u_arb (
    .src_req(src_req), .src_mask(src_mask), .grp_prio(grp_prio), .ext_lvl(ext_lvl),
    .win_vld(win_vld), .win_prio(win_prio), .win_code(win_code)
  );

  gpi_outreg u_out (
    .clk(clk), .rst(rst), .win_vld(win_vld), .win_prio(win_prio), .win_code(win_code),
    .cpu_lvl(cpu_lvl), .irq_req(irq_req), .irq_prio(irq_prio), .irq_code(irq_code)
  );

  AST_EXT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(ext_lvl) == EXT_IDLE && $past(src_req) == '0) |-> (irq_prio == '0 && !irq_req)); // R3
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(ext_lvl) == EXT_IDLE && ($past(src_req) & ~$past(src_mask)) == '0) |-> !irq_req); // R4
endmodule

// File: tb/grp_prio_intc_tb.sv
`timescale 1ns/1ps
module grp_prio_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  src_req = '0;
  logic [3:0]  ext_lvl = 4'hF;
  logic [3:0]  cpu_lvl = '0;
  logic        irq_req;
  logic [11:0] irq_code;
  logic [3:0]  irq_prio;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;
  logic [15:0] cur_prio = '0;
  logic [31:0] cur_mask = '1;

  always #2 clk = ~clk;

  grp_prio_intc dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_req(src_req), .ext_lvl(ext_lvl),
    .cpu_lvl(cpu_lvl), .irq_req(irq_req), .irq_code(irq_code), .irq_prio(irq_prio)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference from the requirements: {req, prio, code}
  function automatic logic [16:0] model(input logic [7:0] pend, input logic [3:0] ext,
                                        input logic [31:0] msk, input logic [15:0] pr,
                                        input logic [3:0] cl);
    logic [3:0]  bp = 4'd0;
    logic [11:0] bc = 12'd0;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] p;
      p = pr[(i/2)*4 +: 4];
      if (pend[i] && !msk[i] && p > bp) begin
        bp = p;
        bc = 12'h400 + 12'(i * 32);
      end
    end
    if (ext != 4'hF && (4'd15 - ext) > bp) begin
      bp = 4'd15 - ext;
      bc = 12'h200 + 12'(ext) * 12'h20;
    end
    return {(bp > cl), bp, bc};
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
    if (a == 3'd0) cur_prio = d[15:0];
    if (a == 3'd4) cur_mask = cur_mask | d;
    if (a == 3'd5) cur_mask = cur_mask & ~d;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    tick();
    chk(tag, rd_data, exp);
  endtask

  // apply inputs, let one edge capture them, compare with model
  task automatic apply_chk(input string tag, input logic [7:0] p, input logic [3:0] e,
                           input logic [3:0] c);
    logic [16:0] exp;
    src_req = p; ext_lvl = e; cpu_lvl = c;
    tick();
    exp = model(p, e, cur_mask, cur_prio, c);
    chk(tag, {15'd0, irq_req, irq_prio, irq_code}, {15'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [15:0] prios [4];
    logic [7:0]  masks [4];
    prios[0] = 16'h4321; prios[1] = 16'h1111; prios[2] = 16'hF0A5; prios[3] = 16'h2F2F;
    masks[0] = 8'h00;    masks[1] = 8'h81;    masks[2] = 8'h3C;    masks[3] = 8'h55;

    src_req = 8'hFF;
    repeat (3) tick();
    chk("R9 outputs in reset", {19'd0, irq_req, irq_prio, irq_code}, 32'd0);
    rst = 1'b0;
    tick();
    chk("R9 outputs after reset", {19'd0, irq_req, irq_prio, irq_code}, 32'd0);
    rd_chk("R9 prio reset", 3'd0, 32'h0);
    rd_chk("R9 mask reset", 3'd4, 32'hFFFF_FFFF);
    src_req = '0;

    // R1 layout and readback
    wr(3'd0, 32'hABCD_4321);
    rd_chk("R1 prio readback", 3'd0, 32'h0000_4321);
    // R10 unused addresses
    for (int a = 1; a < 8; a++) begin
      if (a != 4 && a != 5) rd_chk("R10 unused address", 3'(a), 32'h0);
    end

    // R4 set and clear
    wr(3'd5, 32'h0000_00F0);
    rd_chk("R4 clear", 3'd4, 32'hFFFF_FF0F);
    wr(3'd4, 32'h0000_0010);
    rd_chk("R4 set", 3'd5, 32'hFFFF_FF1F);
    wr(3'd4, 32'h0);
    rd_chk("R4 zero set no effect", 3'd4, 32'hFFFF_FF1F);
    wr(3'd5, 32'h0);
    rd_chk("R4 zero clear no effect", 3'd4, 32'hFFFF_FF1F);
    // source 4 masked: no request
    apply_chk("R4 masked source", 8'h10, 4'hF, 4'd0);
    chk("R4 masked no req", {31'd0, irq_req}, 32'd0);
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk("R4 clear all", 3'd4, 32'h0);

    // R2 each source alone, groups 1..4 priorities
    for (int i = 0; i < 8; i++) begin
      apply_chk("R2 single source", 8'(1 << i), 4'hF, 4'd0);
      chk("R2 code", {20'd0, irq_code}, 32'h400 + 32'(i * 32));
      chk("R1 group prio", {28'd0, irq_prio}, 32'((i / 2) + 1));
    end

    // R3 external level sweep
    for (int l = 0; l < 16; l++) begin
      apply_chk("R3 ext level", 8'h00, 4'(l), 4'd0);
      if (l == 15) chk("R3 idle", {20'd0, irq_code}, 32'h0);
      else         chk("R3 code", {20'd0, irq_code}, 32'h200 + 32'(l * 32));
    end

    // R5 zero priority disables
    wr(3'd0, 32'h0000_0400);
    apply_chk("R5 zero prio", 8'h03, 4'hF, 4'd0);
    chk("R5 no req", {31'd0, irq_req}, 32'd0);
    apply_chk("R5 nonzero group wins", 8'h33, 4'hF, 4'd0);
    chk("R5 code", {20'd0, irq_code}, 32'h480);

    // R8 output holds until the capturing edge
    apply_chk("R8 baseline", 8'h00, 4'hF, 4'd0);
    src_req = 8'h10;
    #1;
    chk("R8 no change before edge", {28'd0, irq_prio}, 32'd0);
    tick();
    chk("R8 change after edge", {28'd0, irq_prio}, 32'd4);

    // R6/R7 sweep over priority and mask configurations
    for (int c = 0; c < 4; c++) begin
      wr(3'd0, {16'd0, prios[c]});
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd4, {24'd0, masks[c]});
      for (int p = 0; p < 256; p++) begin
        apply_chk("R6 R7 sweep", 8'(p), 4'((p * 5 + c) % 16), 4'((p * 7 + c) % 16));
      end
    end

    // R6 tie: equal priority, lowest index wins; external loses on equal
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0000_3333);
    apply_chk("R6 tie lowest index", 8'hA4, 4'hF, 4'd0);
    chk("R6 tie code", {20'd0, irq_code}, 32'h440);
    apply_chk("R6 ext equal loses", 8'h80, 4'd12, 4'd0);
    chk("R6 ext equal code", {20'd0, irq_code}, 32'h4E0);
    apply_chk("R6 ext higher wins", 8'h80, 4'd11, 4'd0);
    chk("R6 ext higher code", {20'd0, irq_code}, 32'h360);
    // R7 level boundary
    apply_chk("R7 equal level", 8'h01, 4'hF, 4'd3);
    chk("R7 equal no req", {31'd0, irq_req}, 32'd0);
    apply_chk("R7 below level", 8'h01, 4'hF, 4'd2);
    chk("R7 below req", {31'd0, irq_req}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule